// File: doc/BRIEF.md
# Hashed Single-Length Prefix Lookup Plane

This block performs an exact-match route lookup for one fixed prefix length. The top bits of a destination address form a key. An XOR fold of the key picks an entry in a small main table. When the stored key in that entry differs from the lookup key, the block runs a binary search over a sorted collision region. That region lives in the same single-port memory, at a base address and length that the main entry supplies. The result is a hit flag and a pointer into a separate forwarding memory. Several instances, one per prefix length, can run side by side, with a longest-length selector placed after them. That selector is not part of this block.

The controller is a four-state machine. `ST_IDLE` serves table writes. It also accepts `start` and issues the main-table read. `ST_MAIN` examines the main entry. It goes to `ST_FIN` on a match, on an invalid entry, or on a mismatch with an empty collision region. Otherwise it issues the first probe and goes to `ST_SUB`. `ST_SUB` examines one probe per cycle. It returns to itself with the next probe, or goes to `ST_FIN` on a match or when the range becomes empty. `ST_FIN` raises `done` for one cycle and always returns to `ST_IDLE`. Because every probe is a separate memory access, the latency depends on how many probes the lookup needs.

Top module: `plen_lookup`

## Requirements
- R1: After reset, `done`, `hit` and `fwd_ptr` are all 0.
- R2: The key is `dst_addr[ADDR_IN_W-1 -: PFX_W]`. Its main-table word address is the XOR of its HASH_W-bit groups, taken from bit 0 upward, with zero bits filling the top of the last group.
- R3: Memory word layout, from the MSB down: valid (1 bit), prefix (PFX_W bits), forwarding pointer (FWD_W bits), region base (ADDR_W bits), region count (CNT_W bits, at the LSBs). Collision entries use only the prefix and forwarding-pointer fields.
- R4: If the main entry is valid and its prefix equals the key, `done` is high during the second cycle after the `start` sample edge, with `hit`=1 and `fwd_ptr` = that entry's pointer.
- R5: If the main entry is invalid, or it mismatches with a count of 0, the lookup ends with the same latency as R4, with `hit`=0 and `fwd_ptr`=0.
- R6: Otherwise the block searches the region [base, base+count), whose prefixes are stored in ascending order. Each probe reads address lo + floor(len/2) and adds one cycle. A key above the probed prefix keeps the upper part of the range, and a key below it keeps the lower part. A match returns the probed entry's pointer with `hit`=1. The maximum number of probes is CNT_W.
- R7: A search whose range becomes empty ends with `hit`=0 and `fwd_ptr`=0.
- R8: `done` is high for exactly one cycle per accepted lookup.
- R9: `start` is ignored while a lookup is in progress. It produces no extra `done` and does not disturb the running lookup.
- R10: While busy, `wr_en` is ignored and memory is unchanged. In the idle state, a write is committed at the clock edge and is visible to the next lookup. If `wr_en` and `start` arrive together in the idle state, the write is taken and `start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a lookup (sampled when idle) |
| dst_addr | input | ADDR_IN_W | Destination address |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Match found (valid with `done`) |
| fwd_ptr | output | FWD_W | Forwarding pointer (valid with `done`) |
| wr_en | input | 1 | Memory write request |
| wr_addr | input | ADDR_W | Memory write address |
| wr_data | input | WORD_W | Memory write word |

## Verification
The hardest cases to reach from the ports are deep searches. These are lookups that need the full CNT_W probes and that fail on either side of the sorted region. The bench builds a 15-entry region and a region with gaps, both filled with keys that all hash to the same bucket. It then looks up every stored key and the keys that fall into the gaps. The busy window is reached by raising `start` and `wr_en` together during such a long search. A later lookup then shows that the write was not committed and that the intruding start produced no extra result.

// File: rtl/plen_lookup_pkg.sv
package plen_lookup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAIN,
        ST_SUB,
        ST_FIN
    } lk_state_t;
endpackage

// File: rtl/xor_fold_hash.sv
module xor_fold_hash #(
    parameter int KEY_W  = 10,
    parameter int HASH_W = 2
) (
    input  logic [KEY_W-1:0]  key,
    output logic [HASH_W-1:0] idx
);
    localparam int NGRP  = (KEY_W + HASH_W - 1) / HASH_W;
    localparam int PAD_W = NGRP * HASH_W;

    logic [PAD_W-1:0] padded;
    logic [HASH_W-1:0] part [NGRP+1];

    // filler bits are zeros above the key
    assign padded  = PAD_W'(key);
    assign part[0] = '0;

    for (genvar g = 0; g < NGRP; g++) begin : g_fold
        assign part[g+1] = part[g] ^ padded[g*HASH_W +: HASH_W];
    end

    assign idx = part[NGRP];
endmodule

// File: rtl/lookup_sram.sv
module lookup_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 26
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/plen_lookup.sv
module plen_lookup
    import plen_lookup_pkg::*;
#(
    parameter int ADDR_IN_W = 32,
    parameter int PFX_W     = 10,
    parameter int HASH_W    = 2,
    parameter int ADDR_W    = 6,
    parameter int FWD_W     = 5,
    parameter int CNT_W     = 4,
    localparam int WORD_W   = 1 + PFX_W + FWD_W + ADDR_W + CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_IN_W-1:0] dst_addr,
    output logic                 done,
    output logic                 hit,
    output logic [FWD_W-1:0]     fwd_ptr,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data
);
    localparam int CNT_LSB  = 0;
    localparam int BASE_LSB = CNT_LSB + CNT_W;
    localparam int FWD_LSB  = BASE_LSB + ADDR_W;
    localparam int PFX_LSB  = FWD_LSB + FWD_W;
    localparam int VLD_BIT  = PFX_LSB + PFX_W;

    lk_state_t state_q, state_d;

    logic [PFX_W-1:0]  key_q;
    logic [ADDR_W-1:0] lo_q, mid_q, rbase_q;
    logic [CNT_W-1:0]  len_q, rcnt_q;
    logic [CNT_W:0]    probe_q;
    logic              hit_q;
    logic [FWD_W-1:0]  ptr_q;

    logic [PFX_W-1:0]  new_key;
    logic [HASH_W-1:0] bucket;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] rdata;

    assign new_key = dst_addr[ADDR_IN_W-1 -: PFX_W];

    xor_fold_hash #(.KEY_W(PFX_W), .HASH_W(HASH_W)) u_hash (
        .key (new_key),
        .idx (bucket)
    );

    lookup_sram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (wr_data),
        .rdata (rdata)
    );

    // fields of the word read in the previous cycle
    logic              e_vld;
    logic [PFX_W-1:0]  e_pfx;
    logic [FWD_W-1:0]  e_fwd;
    logic [ADDR_W-1:0] e_base;
    logic [CNT_W-1:0]  e_cnt;
    assign e_vld  = rdata[VLD_BIT];
    assign e_pfx  = rdata[PFX_LSB +: PFX_W];
    assign e_fwd  = rdata[FWD_LSB +: FWD_W];
    assign e_base = rdata[BASE_LSB +: ADDR_W];
    assign e_cnt  = rdata[CNT_LSB +: CNT_W];

    // range narrowing for the next probe
    logic              key_eq, go_up;
    logic [ADDR_W-1:0] nlo, nmid, first_mid;
    logic [CNT_W-1:0]  nlen;
    assign key_eq    = (e_pfx == key_q);
    assign go_up     = (key_q > e_pfx);
    assign nlo       = go_up ? (mid_q + ADDR_W'(1)) : lo_q;
    assign nlen      = go_up ? (len_q - (len_q >> 1) - CNT_W'(1)) : (len_q >> 1);
    assign nmid      = nlo + ADDR_W'(nlen >> 1);
    assign first_mid = e_base + ADDR_W'(e_cnt >> 1);

    // next state and memory port control
    always_comb begin
        state_d  = state_q;
        mem_we   = 1'b0;
        mem_re   = 1'b0;
        mem_addr = wr_addr;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    mem_we = 1'b1;
                end else if (start) begin
                    mem_re   = 1'b1;
                    mem_addr = ADDR_W'(bucket);
                    state_d  = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if ((e_vld && key_eq) || !e_vld || (e_cnt == '0)) begin
                    state_d = ST_FIN;
                end else begin
                    mem_re   = 1'b1;
                    mem_addr = first_mid;
                    state_d  = ST_SUB;
                end
            end
            ST_SUB: begin
                if (key_eq || (nlen == '0)) begin
                    state_d = ST_FIN;
                end else begin
                    mem_re   = 1'b1;
                    mem_addr = nmid;
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // search datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= '0;
            lo_q    <= '0;
            mid_q   <= '0;
            len_q   <= '0;
            rbase_q <= '0;
            rcnt_q  <= '0;
            probe_q <= '0;
            hit_q   <= 1'b0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!wr_en && start) key_q <= new_key;
                end
                ST_MAIN: begin
                    if (e_vld && key_eq) begin
                        hit_q <= 1'b1;
                        ptr_q <= e_fwd;
                    end else if (!e_vld || (e_cnt == '0)) begin
                        hit_q <= 1'b0;
                        ptr_q <= '0;
                    end else begin
                        lo_q    <= e_base;
                        len_q   <= e_cnt;
                        mid_q   <= first_mid;
                        rbase_q <= e_base;
                        rcnt_q  <= e_cnt;
                        probe_q <= (CNT_W+1)'(1);
                    end
                end
                ST_SUB: begin
                    if (key_eq) begin
                        hit_q <= 1'b1;
                        ptr_q <= e_fwd;
                    end else if (nlen == '0) begin
                        hit_q <= 1'b0;
                        ptr_q <= '0;
                    end else begin
                        lo_q    <= nlo;
                        len_q   <= nlen;
                        mid_q   <= nmid;
                        probe_q <= probe_q + (CNT_W+1)'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done    = (state_q == ST_FIN);
        hit     = hit_q;
        fwd_ptr = ptr_q;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN || state_q == ST_SUB) |=> $stable(key_q));

    // R6
    probe_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUB) |-> (ADDR_W'(mid_q - rbase_q) < ADDR_W'(rcnt_q)));

    // R6
    probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUB) |-> (probe_q <= (CNT_W+1)'(CNT_W)));

    // R7
    miss_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (fwd_ptr == '0));

    // R10
    no_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !mem_we);
endmodule

// File: tb/plen_lookup_bench.sv
module plen_lookup_bench;
    localparam int AIW = 32;
    localparam int L   = 10;
    localparam int H   = 2;
    localparam int AW  = 6;
    localparam int FW  = 5;
    localparam int CW  = 4;
    localparam int WW  = 1 + L + FW + AW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AIW-1:0] dst_addr = '0;
    logic          done, hit;
    logic [FW-1:0] fwd_ptr;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;

    always #4 clk = ~clk;

    plen_lookup #(.ADDR_IN_W(AIW), .PFX_W(L), .HASH_W(H), .ADDR_W(AW),
                  .FWD_W(FW), .CNT_W(CW)) u_plen_lookup (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr),
        .done(done), .hit(hit), .fwd_ptr(fwd_ptr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct {
        bit          e_hit;
        logic [FW-1:0] e_ptr;
        int          e_lat;
        int          t0;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0, fails = 0;
    int          cyc = 0, done_seen = 0;
    logic [WW-1:0] mirror [1<<AW];
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: XOR fold of H-bit groups from bit 0, zero filler on top
    function automatic logic [H-1:0] fold(input logic [L-1:0] k);
        logic [H-1:0] r = '0;
        logic [((L+H-1)/H)*H-1:0] p = '0;
        p[L-1:0] = k;
        for (int g = 0; g < (L+H-1)/H; g++) r ^= p[g*H +: H];
        return r;
    endfunction

    function automatic logic [L-1:0] nth(input int b, input int n);
        int c = 0;
        for (int p = 0; p < (1 << L); p++) begin
            if (fold(L'(p)) == H'(b)) begin
                if (c == n) return L'(p);
                c++;
            end
        end
        return '0;
    endfunction

    // R3 word layout
    function automatic logic [WW-1:0] mk(input bit v, input logic [L-1:0] p,
            input int f, input int base, input int cnt);
        return {v, p, FW'(f), AW'(base), CW'(cnt)};
    endfunction

    // reference lookup built from R4..R7
    task automatic model(input logic [L-1:0] k, output bit h,
                         output logic [FW-1:0] ptr, output int probes);
        logic [WW-1:0] w = mirror[AW'(fold(k))];
        int lo, len, mid;
        h = 0; ptr = '0; probes = 0;
        if (w[WW-1] && w[WW-2 -: L] == k) begin
            h = 1; ptr = w[AW+CW +: FW]; return;
        end
        if (!w[WW-1] || w[CW-1:0] == 0) return;
        lo = int'(w[CW +: AW]); len = int'(w[CW-1:0]);
        while (len > 0) begin
            mid = lo + len / 2;
            probes++;
            w = mirror[AW'(mid)];
            if (w[WW-2 -: L] == k) begin
                h = 1; ptr = w[AW+CW +: FW]; return;
            end else if (k > w[WW-2 -: L]) begin
                lo = mid + 1; len = len - len / 2 - 1;
            end else begin
                len = len / 2;
            end
        end
    endtask

    task automatic wr_word(input int a, input logic [WW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        mirror[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: compute expectation, push, pulse start, wait for result
    task automatic lookup(input logic [L-1:0] k, input string tag);
        exp_t e;
        bit h; logic [FW-1:0] p; int pr;
        int target;
        model(k, h, p, pr);
        @(negedge clk);
        e.e_hit = h; e.e_ptr = p; e.e_lat = 2 + pr; e.t0 = cyc; e.tag = tag;
        sb.push_back(e);
        target = done_seen + 1;
        dst_addr = {k, 22'(int'(k) * 7919 + 3)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (done_seen >= target);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            done_seen++;
            if (sb.size() == 0) begin
                check(0, "R8/R9 unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                check(hit == e.e_hit, {e.tag, " hit"}, int'(hit), int'(e.e_hit));
                check(fwd_ptr == e.e_ptr, {e.tag, " ptr"}, int'(fwd_ptr), int'(e.e_ptr));
                check(cyc - e.t0 == e.e_lat, {e.tag, " latency"}, cyc - e.t0, e.e_lat);
            end
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(hit == 1'b0, "R1 hit", int'(hit), 0);
        check(fwd_ptr == '0, "R1 fwd_ptr", int'(fwd_ptr), 0);
        rst_n = 1'b1;

        for (int a = 0; a < (1 << AW); a++) wr_word(a, '0);
        // bucket 0: single entry, no collisions
        wr_word(0, mk(1, nth(0, 0), 1, 0, 0));
        // bucket 1: left invalid
        // bucket 2: region of 7 with gaps, base 8
        wr_word(2, mk(1, nth(2, 0), 2, 8, 7));
        for (int i = 0; i < 7; i++) wr_word(8 + i, mk(0, nth(2, 2*i + 2), 10 + i, 0, 0));
        // bucket 3: full 15-entry region, base 24
        wr_word(3, mk(1, nth(3, 0), 4, 24, 15));
        for (int i = 0; i < 15; i++) wr_word(24 + i, mk(0, nth(3, i + 1), 16 + i, 0, 0));

        lookup(nth(0, 0), "R2/R4 main hit b0");
        lookup(nth(0, 1), "R5 mismatch count 0");
        lookup(nth(1, 0), "R5 invalid entry");
        lookup(nth(2, 0), "R4 main hit b2");
        lookup(nth(3, 0), "R4 main hit b3");
        for (int i = 0; i < 7; i++) lookup(nth(2, 2*i + 2), "R6 region hit b2");
        lookup(nth(2, 1), "R7 below region");
        lookup(nth(2, 7), "R7 gap in region");
        lookup(nth(2, 15), "R7 above region");
        for (int i = 0; i < 15; i++) lookup(nth(3, i + 1), "R6 deep region b3");
        lookup(nth(3, 16), "R7 past full region");

        // R9 and R10: start and write while busy
        begin
            exp_t e;
            bit h; logic [FW-1:0] p; int pr;
            model(nth(3, 1), h, p, pr);
            @(negedge clk);
            e.e_hit = h; e.e_ptr = p; e.e_lat = 2 + pr; e.t0 = cyc;
            e.tag = "R9 long lookup under intrusion";
            sb.push_back(e);
            n0 = done_seen;
            dst_addr = {nth(3, 1), 22'h0A5A5};
            start = 1'b1;
            @(negedge clk);
            start = 1'b1;
            dst_addr = {nth(0, 0), 22'h1};
            wr_en = 1'b1; wr_addr = '0; wr_data = mk(1, nth(0, 0), 30, 0, 0);
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            wait (done_seen >= n0 + 1);
            repeat (8) @(negedge clk);
            check(done_seen == n0 + 1, "R9 extra done count", done_seen - n0, 1);
        end
        lookup(nth(0, 0), "R10 busy write ignored");

        // R10: idle write takes effect
        wr_word(1, mk(1, nth(1, 0), 7, 0, 0));
        lookup(nth(1, 0), "R10 idle write visible");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R8 pending results", sb.size(), 0);
        summary();
    end
endmodule